// File: doc/BRIEF.md
# Odd-Multiple Table Constant Multiplier

This block multiplies an unsigned operand by a coefficient fixed at elaboration time, without a multiplier array and without a table holding every product. It keeps only the odd multiples of the coefficient, plus one word of zero. Every even product is an odd multiple moved left by a few bit positions.

An encoder splits the operand `x` into two parts. The first is the number of trailing zero bits, which becomes the shift amount. The second is the odd part that remains, which selects the table entry holding `COEF * odd`. For `x = 0` the encoder selects the zero word with no shift. A logarithmic barrel shifter applies the shift, and a single output register captures the result. A product therefore appears one clock after its operand. The output-valid flag is delayed by the same clock so that it stays aligned with the product.

Top module: `omult_constmul`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `out_prod` equals the exact product `in_x * COEF`, with no truncation, in `COEF_W + IN_W` bits.
- R2: `out_valid` is `in_valid` delayed by exactly one clock.
- R3: While `in_valid` is low, `out_prod` keeps its previous value, whatever `in_x` carries.
- R4: An operand of zero gives a product of zero, read from the table's dedicated zero word with a shift of zero.
- R5: For an odd operand `x`, the product comes from the table entry at index `(x-1)/2`. The table holds `2^(IN_W-1)` odd multiples plus the zero word, and an odd operand is not shifted.
- R6: For a nonzero even operand, the shift amount equals the number of trailing zero bits of `x`, up to `IN_W-1`. For example, `x = 2^(IN_W-1)` yields `COEF` shifted left by `IN_W-1`.
- R7: While `rst_n` is low, and on the first edge after it goes high, `out_valid` and `out_prod` are 0.
- R8: The largest coefficient `2^COEF_W-1` times the largest operand `2^IN_W-1` appears at `out_prod` without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand qualifier |
| in_x | input | IN_W | Unsigned operand |
| out_valid | output | 1 | Product qualifier, one clock after `in_valid` |
| out_prod | output | COEF_W+IN_W | Registered product `in_x * COEF` |

## Verification
The bench drives every operand value through four instances with different operand widths and coefficients, including an all-ones coefficient. This exposes any error in trailing-zero detection, such as counting from the wrong end or stopping early. Such an error shows up as the right odd multiple scaled by the wrong power of two, or as the wrong odd multiple altogether. The zero operand is checked on its own. An encoder that did not route it to the zero word would return the coefficient itself or an odd multiple. The operand `2^(IN_W-1)` exercises the widest shift; a shifter missing its top stage returns a product too small by a power of two. Idle cycles with a changing operand show whether the output register loads without its qualifier, which would leave `out_prod` tracking the input instead of holding.

// File: rtl/omult_pkg.sv
package omult_pkg;
   // Number of select bits needed for a shift range of 0 .. in_w-1.
   function automatic int shift_sel_bits(input int in_w);
      int b;
      b = $clog2(in_w);
      return (b < 1) ? 1 : b;
   endfunction
endpackage

// File: rtl/omult_addr_enc.sv
module omult_addr_enc #(
   parameter int IN_W   = 4,
   parameter int ADDR_W = IN_W - 1,
   parameter int SH_W   = 2
) (
   input  logic [IN_W-1:0]   x,
   output logic [ADDR_W-1:0] addr,
   output logic [SH_W-1:0]   sh,
   output logic              zsel
);
   logic [IN_W-1:0] odd_part;

   always_comb begin
      sh = '0;
      // Walk from the top so that the lowest set bit wins.
      for (int i = IN_W - 1; i >= 0; i--) begin
         if (x[i]) sh = SH_W'(i);
      end
      zsel     = (x == '0);
      odd_part = x >> sh;
      addr     = zsel ? '0 : ADDR_W'(odd_part >> 1);
   end
endmodule

// File: rtl/omult_odd_rom.sv
module omult_odd_rom #(
   parameter int              IN_W   = 4,
   parameter int              COEF_W = 8,
   parameter logic [COEF_W-1:0] COEF = '1,
   parameter int              PROD_W = COEF_W + IN_W,
   parameter int              ADDR_W = IN_W - 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              zsel,
   output logic [PROD_W-1:0] word
);
   localparam int HALF  = 2 ** (IN_W - 1);
   localparam int DEPTH = HALF + 1;

   logic [PROD_W-1:0] table_w [DEPTH];

   for (genvar i = 0; i < HALF; i++) begin : g_odd
      assign table_w[i] = PROD_W'(COEF) * PROD_W'(2 * i + 1);
   end
   assign table_w[HALF] = '0;

   assign word = zsel ? table_w[HALF] : table_w[addr];
endmodule

// File: rtl/omult_lshift.sv
module omult_lshift #(
   parameter int DATA_W = 12,
   parameter int SH_W   = 2
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SH_W-1:0]   sh,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] stage [SH_W+1];

   assign stage[0] = din;
   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      assign stage[s+1] = sh[s] ? (stage[s] << (2 ** s)) : stage[s];
   end
   assign dout = stage[SH_W];
endmodule

// File: rtl/omult_constmul.sv
module omult_constmul
   import omult_pkg::*;
#(
   parameter int                IN_W   = 4,
   parameter int                COEF_W = 8,
   parameter logic [COEF_W-1:0] COEF   = 8'd13
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [IN_W-1:0]          in_x,
   output logic                     out_valid,
   output logic [COEF_W+IN_W-1:0]   out_prod
);
   localparam int PROD_W = COEF_W + IN_W;
   localparam int ADDR_W = IN_W - 1;
   localparam int SH_W   = shift_sel_bits(IN_W);

   if (IN_W < 2) begin : g_bad_in_w
      $error("omult_constmul: IN_W must be at least 2");
   end
   if (COEF_W < 1) begin : g_bad_coef_w
      $error("omult_constmul: COEF_W must be at least 1");
   end
   if (IN_W > 16) begin : g_big_in_w
      $error("omult_constmul: IN_W above 16 makes an oversized table");
   end

   logic [ADDR_W-1:0] enc_addr;
   logic [SH_W-1:0]   enc_sh;
   logic              enc_zero;
   logic [PROD_W-1:0] rom_word;
   logic [PROD_W-1:0] shifted;

   omult_addr_enc #(.IN_W(IN_W), .ADDR_W(ADDR_W), .SH_W(SH_W)) u_enc (
      .x    (in_x),
      .addr (enc_addr),
      .sh   (enc_sh),
      .zsel (enc_zero)
   );

   omult_odd_rom #(.IN_W(IN_W), .COEF_W(COEF_W), .COEF(COEF),
                   .PROD_W(PROD_W), .ADDR_W(ADDR_W)) u_rom (
      .addr (enc_addr),
      .zsel (enc_zero),
      .word (rom_word)
   );

   omult_lshift #(.DATA_W(PROD_W), .SH_W(SH_W)) u_shift (
      .din  (rom_word),
      .sh   (enc_sh),
      .dout (shifted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_prod  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_prod <= shifted;
      end
   end
endmodule

// File: rtl/omult_chk.sv
module omult_chk #(
   parameter int                IN_W   = 4,
   parameter int                COEF_W = 8,
   parameter logic [COEF_W-1:0] COEF   = 8'd13,
   parameter int                SH_W   = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic [IN_W-1:0]        in_x,
   input logic                   out_valid,
   input logic [COEF_W+IN_W-1:0] out_prod,
   input logic [SH_W-1:0]        enc_sh,
   input logic                   enc_zero
);
   localparam int PROD_W = COEF_W + IN_W;

   assert_exact_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_prod == PROD_W'($past(in_x)) * PROD_W'(COEF));

   assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_prod));

   assert_zero_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_x == '0) |=> out_prod == '0);

   assert_zero_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      enc_zero |-> (in_x == '0 && enc_sh == '0));

   assert_shift_hits_set_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !enc_zero |-> (in_x[enc_sh] == 1'b1 && int'(enc_sh) < IN_W));

   assert_reset_clear_R7: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_prod == '0));
endmodule

bind omult_constmul omult_chk #(
   .IN_W(IN_W), .COEF_W(COEF_W), .COEF(COEF), .SH_W(SH_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_x      (in_x),
   .out_valid (out_valid),
   .out_prod  (out_prod),
   .enc_sh    (enc_sh),
   .enc_zero  (enc_zero)
);

// File: tb/sim_omult_constmul.sv
`timescale 1ns/1ps
module sim_omult_constmul;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // u0: IN_W=4, COEF_W=8, COEF=13
   logic       v0;  logic [3:0] x0;  logic ov0;  logic [11:0] p0;
   // u1: IN_W=4, COEF_W=8, COEF=255 (largest)
   logic       v1;  logic [3:0] x1;  logic ov1;  logic [11:0] p1;
   // u2: IN_W=6, COEF_W=5, COEF=21
   logic       v2;  logic [5:0] x2;  logic ov2;  logic [10:0] p2;
   // u3: IN_W=3, COEF_W=4, COEF=11
   logic       v3;  logic [2:0] x3;  logic ov3;  logic [6:0]  p3;

   omult_constmul #(.IN_W(4), .COEF_W(8), .COEF(8'd13)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_x(x0), .out_valid(ov0), .out_prod(p0));
   omult_constmul #(.IN_W(4), .COEF_W(8), .COEF(8'd255)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_x(x1), .out_valid(ov1), .out_prod(p1));
   omult_constmul #(.IN_W(6), .COEF_W(5), .COEF(5'd21)) u2 (
      .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_x(x2), .out_valid(ov2), .out_prod(p2));
   omult_constmul #(.IN_W(3), .COEF_W(4), .COEF(4'd11)) u3 (
      .clk(clk), .rst_n(rst_n), .in_valid(v3), .in_x(x3), .out_valid(ov3), .out_prod(p3));

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic string tag_for(input int x);
      if (x == 0) return "R4 zero operand";
      if (x % 2 == 1) return "R5 odd operand";
      return "R6 even operand";
   endfunction

   task automatic drive(input bit vld, input int v);
      v0 = vld; v1 = vld; v2 = vld; v3 = vld;
      x0 = 4'(v); x1 = 4'(v); x2 = 6'(v); x3 = 3'(v);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   longint last0, last1, last2, last3;

   initial begin
      drive(1'b0, 0);
      repeat (3) step();
      // R7: outputs clear while reset is held
      check("R7 reset valid u0", ov0, 0);
      check("R7 reset prod u0", p0, 0);
      check("R7 reset prod u1", p1, 0);
      check("R7 reset prod u2", p2, 0);
      check("R7 reset prod u3", p3, 0);
      rst_n = 1'b1;
      step();
      check("R7 first edge after reset valid u2", ov2, 0);
      check("R7 first edge after reset prod u2", p2, 0);

      // Exhaustive sweep, all instances valid every cycle (R1, R2, R4, R5, R6, R8)
      for (int v = 0; v < 64; v++) begin
         drive(1'b1, v);
         step();
         check({"R1 ", tag_for(v % 16), " u0"}, p0, longint'(v % 16) * 13);
         check({"R8 ", tag_for(v % 16), " u1"}, p1, longint'(v % 16) * 255);
         check({"R1 ", tag_for(v), " u2"}, p2, longint'(v) * 21);
         check({"R1 ", tag_for(v % 8), " u3"}, p3, longint'(v % 8) * 11);
         check("R2 valid follows u0", ov0, 1);
      end

      // R6: widest shift, operand 2^(IN_W-1)
      drive(1'b1, 32);
      step();
      check("R6 max shift u2", p2, 21 << 5);
      drive(1'b1, 8);
      step();
      check("R6 max shift u0", p0, 13 << 3);
      check("R6 max shift u1", p1, 255 << 3);
      // R8: largest operand with largest coefficient
      drive(1'b1, 15);
      step();
      check("R8 full scale u1", p1, 15 * 255);
      last0 = 15 * 13; last1 = 15 * 255; last2 = 15 * 21; last3 = 7 * 11;

      // R3: idle cycles with a moving operand, product must hold
      for (int k = 1; k < 6; k++) begin
         drive(1'b0, k * 9);
         step();
         check("R2 valid low when idle u0", ov0, 0);
         check("R3 hold u0", p0, last0);
         check("R3 hold u1", p1, last1);
         check("R3 hold u2", p2, last2);
         check("R3 hold u3", p3, last3);
      end

      // R2: single valid pulse after idle
      drive(1'b1, 6);
      step();
      check("R2 pulse valid u3", ov3, 1);
      check("R6 even after idle u3", p3, 66);
      drive(1'b0, 0);
      step();
      check("R2 pulse ends u3", ov3, 0);
      check("R3 hold after pulse u3", p3, 66);
      check("R4 idle zero operand not loaded u0", p0, 6 * 13);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule